// File: doc/BRIEF.md
# Indirect Call Target Buffer with Two-Miss Replacement

This block predicts where an indirect call will jump, using only the address of the call instruction. A direct-mapped table, indexed by low-order bits of the call-site address, holds one target per entry together with a valid bit and a one-bit pending-miss flag. The fetch side presents a call-site address and gets back the stored target and a valid indication in the same cycle. The execute side later reports the resolved call, giving the call-site address and the real target. The block then updates the entry.

Two replacement policies are selectable at run time. In the plain policy, every wrong prediction overwrites the stored target. In the hysteresis policy, the stored target survives a single wrong prediction and is only replaced when the same entry has mispredicted twice in a row. A correct prediction in between cancels the pending miss. Entries carry no tag, so call sites that share index bits share one prediction. Two saturating counters report how many calls were resolved and how many of those were mispredicted, so the two policies can be compared.

Top module: `call_target_buffer`

## Requirements
- R1: The entry is selected by call-site address bits [ALIGN+IDX_W-1:ALIGN], which are bits [9:2] with the defaults (256 entries, ALIGN=2). Addresses that differ only in other bits use the same entry and get the same prediction, because there is no tag.
- R2: Lookup is combinational. `lk_hit` equals the valid bit of the selected entry. `lk_target` is the stored target when the entry is valid, and zero when it is not.
- R3: Resolving a call whose entry is invalid writes the actual target, marks the entry valid and clears its pending-miss flag. This happens under both policies.
- R4: With `hyst_mode`=0 (plain policy), every resolution whose actual target differs from the stored target overwrites the stored target.
- R5: With `hyst_mode`=1 (hysteresis policy), a mismatch on an entry whose flag is clear keeps the target and sets the flag. A mismatch on an entry whose flag is set replaces the target and clears the flag.
- R6: A resolution whose actual target equals the stored target clears the flag. So under the hysteresis policy the sequence miss, hit, miss leaves the original target in place.
- R7: An update takes effect at the rising clock edge at which `up_valid` is 1. A lookup of the same entry in that cycle returns the old contents. While `up_valid` is 0, the update inputs change nothing.
- R8: A synchronous reset (`rst`=1 at a rising edge) makes every entry invalid, clears every flag and zeroes both counters.
- R9: `stat_resolved` increases by one for each update, and holds at all ones once it gets there.
- R10: `stat_mispred` increases by one for each update that finds its entry invalid or finds a target different from the actual one. It holds at all ones once it gets there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hyst_mode | input | 1 | 0: replace on every miss; 1: replace after two consecutive misses |
| lk_pc | input | ADDR_W | Call-site address to look up |
| lk_hit | output | 1 | Selected entry holds a valid target |
| lk_target | output | ADDR_W | Predicted target, zero when not valid |
| up_valid | input | 1 | Resolution strobe |
| up_pc | input | ADDR_W | Call-site address of the resolved call |
| up_target | input | ADDR_W | Actual target of the resolved call |
| stat_resolved | output | CNT_W | Saturating count of resolutions |
| stat_mispred | output | CNT_W | Saturating count of mispredicted resolutions |

## Verification
The hardest state to reach is an entry whose pending-miss flag is set. The flag is not visible at the ports, and it only shows up in what the next resolution does to the target. The stimulus drives the flag on purpose: it fills an entry, sends one mismatching target, and then either sends a second mismatch (the target must change) or a correct target followed by another mismatch (the target must survive). Lookups between the steps expose the result. Counter saturation is reached with a reduced counter width and a few hundred back-to-back resolutions.

// File: rtl/ctb_pkg.sv
package ctb_pkg;

  typedef enum logic {
    POL_REPLACE = 1'b0,
    POL_HYST    = 1'b1
  } ctb_policy_e;

  // What one resolution does to its entry
  typedef struct packed {
    logic miss;       // prediction was absent or wrong
    logic write_tgt;  // overwrite stored target
    logic set_valid;  // entry becomes valid
    logic set_flag;   // arm pending-miss flag
    logic clr_flag;   // disarm pending-miss flag
  } ctb_action_t;

  // Replacement rule, kept as a function so it reads as a table
  function automatic ctb_action_t ctb_decide(input logic        valid,
                                             input logic        match,
                                             input logic        flag,
                                             input ctb_policy_e pol);
    ctb_action_t a;
    a = '0;
    a.miss = !valid || !match;
    if (!valid) begin
      a.write_tgt = 1'b1;
      a.set_valid = 1'b1;
      a.clr_flag  = 1'b1;
    end else if (match) begin
      a.clr_flag  = 1'b1;
    end else if (pol == POL_REPLACE) begin
      a.write_tgt = 1'b1;
      a.clr_flag  = 1'b1;
    end else if (!flag) begin
      a.set_flag  = 1'b1;
    end else begin
      a.write_tgt = 1'b1;
      a.clr_flag  = 1'b1;
    end
    return a;
  endfunction

  // Next value of a saturating counter
  function automatic logic [63:0] ctb_sat_next(input logic [63:0] cur,
                                               input logic [63:0] max);
    return (cur >= max) ? max : cur + 64'd1;
  endfunction

endpackage

// File: rtl/ctb_index.sv
module ctb_index #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int ALIGN  = 2
) (
  input  logic [ADDR_W-1:0] pc,
  output logic [IDX_W-1:0]  idx
);
  localparam int LO = ALIGN;
  localparam int HI = ALIGN + IDX_W - 1;

  // Low-order word bits select the entry; nothing else is kept (no tag)
  assign idx = pc[HI:LO];

endmodule

// File: rtl/ctb_store.sv
module ctb_store #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  // lookup read port
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_tgt,
  // update read/modify port
  input  logic [IDX_W-1:0]  up_idx,
  output logic              up_valid_q,
  output logic              up_flag_q,
  output logic [ADDR_W-1:0] up_tgt_q,
  input  logic              wr_en,
  input  logic              wr_tgt_en,
  input  logic [ADDR_W-1:0] wr_tgt,
  input  logic              wr_set_valid,
  input  logic              wr_set_flag,
  input  logic              wr_clr_flag
);
  logic [ADDR_W-1:0] tgt_mem [DEPTH];
  logic [DEPTH-1:0]  valid_q;
  logic [DEPTH-1:0]  flag_q;

  // Target storage carries no reset; valid bits gate its use
  always_ff @(posedge clk) begin
    if (wr_en && wr_tgt_en && !rst)
      tgt_mem[up_idx] <= wr_tgt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      flag_q  <= '0;
    end else if (wr_en) begin
      if (wr_set_valid)
        valid_q[up_idx] <= 1'b1;
      if (wr_set_flag)
        flag_q[up_idx] <= 1'b1;
      else if (wr_clr_flag)
        flag_q[up_idx] <= 1'b0;
    end
  end

  // Both read ports see contents from before the current edge
  assign rd_valid   = valid_q[rd_idx];
  assign rd_tgt     = tgt_mem[rd_idx];
  assign up_valid_q = valid_q[up_idx];
  assign up_flag_q  = flag_q[up_idx];
  assign up_tgt_q   = tgt_mem[up_idx];

endmodule

// File: rtl/ctb_satcnt.sv
module ctb_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  import ctb_pkg::*;

  localparam logic [63:0] MAXV = (64'd1 << W) - 64'd1;

  logic [63:0] nxt;

  always_comb begin
    nxt = ctb_sat_next(64'(count), MAXV);
  end

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (inc)
      count <= nxt[W-1:0];
  end

endmodule

// File: rtl/call_target_buffer.sv
module call_target_buffer #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 256,
  parameter int ALIGN  = 2,
  parameter int CNT_W  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hyst_mode,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic [ADDR_W-1:0] up_target,
  output logic [CNT_W-1:0]  stat_resolved,
  output logic [CNT_W-1:0]  stat_mispred
);
  import ctb_pkg::*;

  // Named internal events, observed by the bound checker
  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  up_idx;
  logic              rd_valid;
  logic [ADDR_W-1:0] rd_tgt;
  logic              e_valid;
  logic              e_flag;
  logic [ADDR_W-1:0] e_tgt;
  ctb_action_t       act;
  logic              upd_miss;
  logic              upd_replace;

  ctb_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) u_lk_index (
    .pc  (lk_pc),
    .idx (lk_idx)
  );

  ctb_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) u_up_index (
    .pc  (up_pc),
    .idx (up_idx)
  );

  // Replacement decision for the entry being resolved
  always_comb begin
    act = ctb_decide(e_valid, (e_tgt == up_target), e_flag,
                     ctb_policy_e'(hyst_mode));
  end

  assign upd_miss    = up_valid && act.miss;
  assign upd_replace = up_valid && act.write_tgt;

  ctb_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
    .clk          (clk),
    .rst          (rst),
    .rd_idx       (lk_idx),
    .rd_valid     (rd_valid),
    .rd_tgt       (rd_tgt),
    .up_idx       (up_idx),
    .up_valid_q   (e_valid),
    .up_flag_q    (e_flag),
    .up_tgt_q     (e_tgt),
    .wr_en        (up_valid),
    .wr_tgt_en    (act.write_tgt),
    .wr_tgt       (up_target),
    .wr_set_valid (act.set_valid),
    .wr_set_flag  (act.set_flag),
    .wr_clr_flag  (act.clr_flag)
  );

  // Prediction: invalid entries show a zero target
  assign lk_hit    = rd_valid;
  assign lk_target = rd_valid ? rd_tgt : '0;

  ctb_satcnt #(.W(CNT_W)) u_cnt_resolved (
    .clk   (clk),
    .rst   (rst),
    .inc   (up_valid),
    .count (stat_resolved)
  );

  ctb_satcnt #(.W(CNT_W)) u_cnt_mispred (
    .clk   (clk),
    .rst   (rst),
    .inc   (upd_miss),
    .count (stat_mispred)
  );

endmodule

// File: rtl/ctb_checker.sv
module ctb_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              hyst_mode,
  input logic              up_valid,
  input logic [ADDR_W-1:0] up_target,
  input logic [IDX_W-1:0]  lk_idx,
  input logic [IDX_W-1:0]  up_idx,
  input logic              lk_hit,
  input logic [ADDR_W-1:0] lk_target,
  input logic              e_valid,
  input logic              e_flag,
  input logic              upd_miss,
  input logic              upd_replace,
  input logic [CNT_W-1:0]  stat_resolved,
  input logic [CNT_W-1:0]  stat_mispred
);

  // R8
  reset_clears_chk: assert property (@(posedge clk) rst |=> !lk_hit);

  // R4
  replace_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (up_valid && upd_replace) |=>
      (!(lk_idx == $past(up_idx)) || (lk_hit && lk_target == $past(up_target))));

  // R5
  hyst_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (up_valid && hyst_mode && e_valid && upd_replace) |-> e_flag);

  // R9
  resolved_step_chk: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> ((stat_resolved == $past(stat_resolved) + 1'b1) ||
                  ($past(stat_resolved) == {CNT_W{1'b1}})));

  // R10
  mispred_bound_chk: assert property (@(posedge clk) disable iff (rst)
    stat_mispred <= stat_resolved);

  // R10
  mispred_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_miss |=> $stable(stat_mispred));

endmodule

bind call_target_buffer ctb_checker #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .hyst_mode     (hyst_mode),
  .up_valid      (up_valid),
  .up_target     (up_target),
  .lk_idx        (lk_idx),
  .up_idx        (up_idx),
  .lk_hit        (lk_hit),
  .lk_target     (lk_target),
  .e_valid       (e_valid),
  .e_flag        (e_flag),
  .upd_miss      (upd_miss),
  .upd_replace   (upd_replace),
  .stat_resolved (stat_resolved),
  .stat_mispred  (stat_mispred)
);

// File: tb/call_target_buffer_bench.sv
module call_target_buffer_bench;
  localparam int AW = 32;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hyst_mode = 1'b0;
  logic [AW-1:0] lk_pc = '0;
  logic          lk_hit;
  logic [AW-1:0] lk_target;
  logic          up_valid = 1'b0;
  logic [AW-1:0] up_pc = '0;
  logic [AW-1:0] up_target = '0;
  logic [CW-1:0] stat_resolved;
  logic [CW-1:0] stat_mispred;

  int checks = 0;
  int fails  = 0;
  int exp_res = 0;
  int exp_mis = 0;

  localparam logic [AW-1:0] PA = 32'h0000_1004;  // entry 1
  localparam logic [AW-1:0] PB = 32'h0000_1008;  // entry 2
  localparam logic [AW-1:0] PC = 32'h0000_100C;  // entry 3
  localparam logic [AW-1:0] PD = 32'h0000_1010;  // entry 4
  localparam logic [AW-1:0] PE = 32'h0000_1014;  // entry 5
  localparam logic [AW-1:0] PF = 32'h0000_1020;  // entry 8
  localparam logic [AW-1:0] T1 = 32'hAAAA_0100;
  localparam logic [AW-1:0] T2 = 32'hBBBB_0200;
  localparam logic [AW-1:0] T3 = 32'hCCCC_0300;
  localparam logic [AW-1:0] T9 = 32'h9999_0900;

  always #4 clk = ~clk;  // 125 MHz

  call_target_buffer #(.ADDR_W(AW), .DEPTH(256), .ALIGN(2), .CNT_W(CW)) u_call_target_buffer (
    .clk(clk), .rst(rst), .hyst_mode(hyst_mode),
    .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_target(lk_target),
    .up_valid(up_valid), .up_pc(up_pc), .up_target(up_target),
    .stat_resolved(stat_resolved), .stat_mispred(stat_mispred)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v >= CMAX) ? CMAX : v + 1;
  endfunction

  task automatic resolve(input logic [AW-1:0] pc, input logic [AW-1:0] tgt, input bit miss);
    @(negedge clk);
    up_valid = 1'b1; up_pc = pc; up_target = tgt;
    @(negedge clk);
    up_valid = 1'b0;
    exp_res = sat(exp_res);
    if (miss) exp_mis = sat(exp_mis);
  endtask

  task automatic probe(input string req, input logic [AW-1:0] pc,
                       input logic hit, input logic [AW-1:0] tgt);
    @(negedge clk);
    lk_pc = pc;
    #1;
    check(req, {31'd0, lk_hit}, {31'd0, hit});
    check(req, lk_target, tgt);
  endtask

  task automatic check_counts(input string req);
    check({req, " resolved"}, AW'(stat_resolved), AW'(exp_res));
    check({req, " mispred"},  AW'(stat_mispred),  AW'(exp_mis));
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    exp_res = 0; exp_mis = 0;
  endtask

  task automatic t_reset_state();
    probe("R8 reset lookup", PA, 1'b0, '0);
    check_counts("R8 reset");
  endtask

  task automatic t_fill();
    hyst_mode = 1'b1;
    probe("R2 invalid entry", PA, 1'b0, '0);
    resolve(PA, T1, 1'b1);
    probe("R3 fill hyst", PA, 1'b1, T1);
    hyst_mode = 1'b0;
    resolve(PB, T1, 1'b1);
    probe("R3 fill plain", PB, 1'b1, T1);
  endtask

  task automatic t_plain_replace();
    hyst_mode = 1'b0;
    resolve(PB, T2, 1'b1);
    probe("R4 first miss replaces", PB, 1'b1, T2);
    resolve(PB, T3, 1'b1);
    probe("R4 second miss replaces", PB, 1'b1, T3);
  endtask

  task automatic t_hysteresis();
    hyst_mode = 1'b1;
    resolve(PC, T1, 1'b1);
    resolve(PC, T2, 1'b1);
    probe("R5 one miss keeps", PC, 1'b1, T1);
    resolve(PC, T3, 1'b1);
    probe("R5 two misses replace", PC, 1'b1, T3);
  endtask

  task automatic t_flag_clear();
    hyst_mode = 1'b1;
    resolve(PD, T1, 1'b1);
    resolve(PD, T2, 1'b1);
    resolve(PD, T1, 1'b0);
    resolve(PD, T2, 1'b1);
    probe("R6 hit clears flag", PD, 1'b1, T1);
    resolve(PD, T2, 1'b1);
    probe("R6 then two misses replace", PD, 1'b1, T2);
  endtask

  task automatic t_alias();
    hyst_mode = 1'b0;
    resolve(PE, T3, 1'b1);
    probe("R1 alias shares entry", PE + 32'h400, 1'b1, T3);
    probe("R1 next index separate", PE + 32'h4, 1'b0, '0);
  endtask

  task automatic t_same_cycle();
    hyst_mode = 1'b0;
    @(negedge clk);
    up_valid = 1'b1; up_pc = PA; up_target = T9; lk_pc = PA;
    #1;
    check("R7 same-cycle old target", lk_target, T1);
    @(negedge clk);
    up_valid = 1'b0;
    exp_res = sat(exp_res); exp_mis = sat(exp_mis);
    #1;
    check("R7 new target after edge", lk_target, T9);
    up_pc = PA; up_target = T2;
    @(negedge clk);
    @(negedge clk);
    probe("R7 strobe low no write", PA, 1'b1, T9);
    check_counts("R7 strobe low");
  endtask

  task automatic t_counts();
    check_counts("R9 R10 running");
  endtask

  task automatic t_mid_reset();
    do_reset();
    probe("R8 reset invalidates", PA, 1'b0, '0);
    probe("R8 reset invalidates b", PD, 1'b0, '0);
    check_counts("R8 mid reset");
    hyst_mode = 1'b1;
    resolve(PD, T3, 1'b1);
    resolve(PD, T1, 1'b1);
    probe("R8 flag cleared by reset", PD, 1'b1, T3);
  endtask

  task automatic t_saturation();
    do_reset();
    hyst_mode = 1'b0;
    for (int i = 0; i < 300; i++) resolve(PF, T1, (i == 0));
    check_counts("R9 resolved saturates");
    for (int i = 0; i < 300; i++) resolve(PF, (i % 2 == 0) ? T2 : T1, 1'b1);
    check_counts("R10 mispred saturates");
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_fill();
    t_plain_replace();
    t_hysteresis();
    t_flag_clear();
    t_alias();
    t_same_cycle();
    t_counts();
    t_mid_reset();
    t_saturation();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule